// File: doc/BRIEF.md
# Self-Detecting Polarity SPI Target

This block is a serial peripheral interface target that needs no clock-mode setting. Its serial inputs are brought into a faster system clock through synchronisers. At the instant its active-low select goes active it looks at the serial clock. A low clock means the controller runs with an idle-low clock, which is mode 0. A high clock means an idle-high clock, which is mode 3. The detected mode is reported on a status output.

In both of these modes data is captured on the rising serial clock edge. Outgoing data is changed on the falling edge that follows a capture. Because of this, one shift datapath serves both modes.

On the system side there are two byte paths. A received byte appears with a one-cycle valid strobe. A byte to transmit is offered with a valid/ready handshake. It is kept in a holding register until a byte boundary, or the next select, moves it into the shifter. The system clock must run at least four times the serial clock rate.

Top module: `spi_autopol_target`

## Requirements
- R1: At each select assertion, `det_mode` is set to 0 if the synchronised serial clock is low at that moment, or to 3 if it is high. The value holds until the next select assertion, including while deselected.
- R2: While selected, MOSI is captured on every rising serial clock edge, most significant bit first. After the eighth capture, `rx_byte` carries the byte and `rx_valid` is high for exactly one system clock.
- R3: The most significant bit of the byte loaded at select assertion appears on `spi_miso` before the first rising edge. Each following bit changes only on the falling edge that comes after a rising edge.
- R4: `spi_miso_oe` is low while the synchronised select is inactive. It is high from select assertion until deassertion.
- R5: `tx_ready` is high when the holding register is empty. A byte is accepted in a cycle where `tx_valid` and `tx_ready` are both high, and `tx_ready` then drops. The held byte is moved to the shifter at select assertion or at a byte boundary, and `tx_ready` returns high.
- R6: If the holding register is empty when a byte is due, the fill byte (default 8'h00) is shifted out instead.
- R7: If select deasserts before eight rising edges, the partial byte produces no `rx_valid`. The next select starts a fresh byte at bit 7.
- R8: Within one select, bytes follow each other without a gap. Every eight rising edges close a byte, and the next transmit byte is taken on the following falling edge.
- R9: After reset, `rx_valid` is 0, `spi_miso_oe` is 0, `tx_ready` is 1 and `det_mode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the controller |
| spi_cs_n | input | 1 | Active-low target select |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial data to the controller |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_byte` |
| tx_byte | input | 8 | Byte offered for transmission |
| tx_valid | input | 1 | `tx_byte` is offered |
| tx_ready | output | 1 | Holding register is free |
| det_mode | output | 2 | Detected clock mode, 0 or 3 |

## Verification
The hardest case to reach is the byte boundary inside one long select. Here the next transmit byte must be taken on the falling edge, while the holding register was refilled only during the previous byte. In mode 3 that falling edge is also the leading edge of the new byte.

The bench holds select low across two bytes in mode 3. Once `tx_ready` shows that the first byte has left the holding register, it offers a second byte. It then checks both bytes on MISO and both received bytes. A separate scenario deasserts select after four bits, to show that the partial count is dropped.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

   typedef enum logic [1:0] {
      SPI_MODE_IDLE_LOW  = 2'd0,
      SPI_MODE_IDLE_HIGH = 2'd3
   } spi_mode_e;

   function automatic spi_mode_e mode_from_level(input logic sclk_level);
      return sclk_level ? SPI_MODE_IDLE_HIGH : SPI_MODE_IDLE_LOW;
   endfunction

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
   parameter int             WIDTH   = 3,
   parameter int             STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_tgt_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("spi_tgt_sync: WIDTH must be at least 1");
      end
   endgenerate

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
            else        chain <= {chain[STAGES-2:0], d[i]};
         end
         assign q[i] = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/spi_tgt_events.sv
module spi_tgt_events
   import spi_tgt_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sclk_s,
   input  logic      cs_n_s,
   output logic      selected,
   output logic      sel_evt,
   output logic      rise_evt,
   output logic      fall_evt,
   output spi_mode_e mode
);

   logic sclk_q;
   logic cs_n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         cs_n_q <= 1'b1;
      end else begin
         sclk_q <= sclk_s;
         cs_n_q <= cs_n_s;
      end
   end

   assign selected = ~cs_n_s;
   assign sel_evt  = cs_n_q & ~cs_n_s;
   assign rise_evt = selected & ~sel_evt & sclk_s & ~sclk_q;
   assign fall_evt = selected & ~sel_evt & ~sclk_s & sclk_q;

   // Polarity is taken from the idle clock level on the select edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode <= SPI_MODE_IDLE_LOW;
      else if (sel_evt) mode <= mode_from_level(sclk_s);
   end

endmodule

// File: rtl/spi_tgt_rx.sv
module spi_tgt_rx #(
   parameter int DATA_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              selected,
   input  logic              rise_evt,
   input  logic              mosi_s,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_valid,
   output logic              byte_done
);

   localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   logic [CNT_W-1:0]  bit_cnt;
   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] shreg_next;

   generate
      if (MSB_FIRST) begin : g_msb
         assign shreg_next = {shreg[DATA_W-2:0], mosi_s};
      end else begin : g_lsb
         assign shreg_next = {mosi_s, shreg[DATA_W-1:1]};
      end
   endgenerate

   assign byte_done = rise_evt & (bit_cnt == LAST_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt  <= '0;
         shreg    <= '0;
         rx_byte  <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (!selected) begin
            bit_cnt <= '0;
         end else if (rise_evt) begin
            shreg <= shreg_next;
            if (byte_done) begin
               bit_cnt  <= '0;
               rx_byte  <= shreg_next;
               rx_valid <= 1'b1;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/spi_tgt_tx.sv
module spi_tgt_tx #(
   parameter int               DATA_W    = 8,
   parameter bit               MSB_FIRST = 1'b1,
   parameter logic [DATA_W-1:0] FILL     = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              selected,
   input  logic              sel_evt,
   input  logic              rise_evt,
   input  logic              fall_evt,
   input  logic              byte_done,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic              miso,
   output logic              miso_oe
);

   logic [DATA_W-1:0] hold;
   logic              hold_full;
   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] shreg_shift;
   logic [DATA_W-1:0] next_byte;
   logic              armed;
   logic              boundary;
   logic              accept;
   logic              consume;

   assign tx_ready  = ~hold_full;
   assign accept    = tx_valid & ~hold_full;
   assign next_byte = hold_full ? hold : FILL;
   assign consume   = sel_evt | (fall_evt & armed & boundary);

   generate
      if (MSB_FIRST) begin : g_msb
         assign shreg_shift = {shreg[DATA_W-2:0], 1'b0};
         assign miso        = shreg[DATA_W-1];
      end else begin : g_lsb
         assign shreg_shift = {1'b0, shreg[DATA_W-1:1]};
         assign miso        = shreg[0];
      end
   endgenerate

   // Holding register; accept only when empty, so it never meets consume
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold      <= '0;
         hold_full <= 1'b0;
      end else if (accept) begin
         hold      <= tx_byte;
         hold_full <= 1'b1;
      end else if (consume) begin
         hold_full <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg    <= '0;
         armed    <= 1'b0;
         boundary <= 1'b0;
         miso_oe  <= 1'b0;
      end else if (!selected) begin
         armed    <= 1'b0;
         boundary <= 1'b0;
         miso_oe  <= 1'b0;
      end else if (sel_evt) begin
         shreg    <= next_byte;
         armed    <= 1'b0;
         boundary <= 1'b0;
         miso_oe  <= 1'b1;
      end else if (rise_evt) begin
         armed    <= 1'b1;
         boundary <= byte_done;
      end else if (fall_evt && armed) begin
         armed    <= 1'b0;
         boundary <= 1'b0;
         shreg    <= boundary ? next_byte : shreg_shift;
      end
   end

endmodule

// File: rtl/spi_autopol_target.sv
module spi_autopol_target
   import spi_tgt_pkg::*;
#(
   parameter int               DATA_W      = 8,
   parameter int               SYNC_STAGES = 2,
   parameter bit               MSB_FIRST   = 1'b1,
   parameter logic [DATA_W-1:0] FILL_BYTE  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sclk,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              spi_miso_oe,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_valid,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic [1:0]        det_mode
);

   localparam int N_SYNC = 3;
   localparam logic [N_SYNC-1:0] SYNC_RST = 3'b010; // {mosi, cs_n, sclk}

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("spi_autopol_target: DATA_W must be at least 2");
      end
   endgenerate

   logic [N_SYNC-1:0] raw_in;
   logic [N_SYNC-1:0] sync_out;
   logic              sclk_s, cs_s, mosi_s;
   logic              selected, sel_evt, rise_evt, fall_evt, byte_done;
   spi_mode_e         mode;

   assign raw_in = {spi_mosi, spi_cs_n, spi_sclk};
   assign sclk_s = sync_out[0];
   assign cs_s   = sync_out[1];
   assign mosi_s = sync_out[2];

   spi_tgt_sync #(
      .WIDTH  (N_SYNC),
      .STAGES (SYNC_STAGES),
      .RST_VAL(SYNC_RST)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw_in),
      .q    (sync_out)
   );

   spi_tgt_events u_events (
      .clk     (clk),
      .rst_n   (rst_n),
      .sclk_s  (sclk_s),
      .cs_n_s  (cs_s),
      .selected(selected),
      .sel_evt (sel_evt),
      .rise_evt(rise_evt),
      .fall_evt(fall_evt),
      .mode    (mode)
   );

   spi_tgt_rx #(
      .DATA_W   (DATA_W),
      .MSB_FIRST(MSB_FIRST)
   ) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .selected (selected),
      .rise_evt (rise_evt),
      .mosi_s   (mosi_s),
      .rx_byte  (rx_byte),
      .rx_valid (rx_valid),
      .byte_done(byte_done)
   );

   spi_tgt_tx #(
      .DATA_W   (DATA_W),
      .MSB_FIRST(MSB_FIRST),
      .FILL     (FILL_BYTE)
   ) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .selected (selected),
      .sel_evt  (sel_evt),
      .rise_evt (rise_evt),
      .fall_evt (fall_evt),
      .byte_done(byte_done),
      .tx_byte  (tx_byte),
      .tx_valid (tx_valid),
      .tx_ready (tx_ready),
      .miso     (spi_miso),
      .miso_oe  (spi_miso_oe)
   );

   assign det_mode = mode;

endmodule

// File: rtl/spi_autopol_target_chk.sv
module spi_autopol_target_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_sync,
   input logic       sel_evt,
   input logic       rise_evt,
   input logic       fall_evt,
   input logic       rx_valid,
   input logic       tx_valid,
   input logic       tx_ready,
   input logic       spi_miso,
   input logic       spi_miso_oe,
   input logic [1:0] det_mode
);

   p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (det_mode == 2'd0) || (det_mode == 2'd3));

   p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_evt |=> $stable(det_mode));

   p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   p_valid_after_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(rise_evt));

   p_miso_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel_evt || fall_evt) |=> $stable(spi_miso));

   p_oe_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cs_sync |=> !spi_miso_oe);

   p_oe_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sel_evt |=> spi_miso_oe);

   p_ready_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> !tx_ready);

endmodule

bind spi_autopol_target spi_autopol_target_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_sync    (cs_s),
   .sel_evt    (sel_evt),
   .rise_evt   (rise_evt),
   .fall_evt   (fall_evt),
   .rx_valid   (rx_valid),
   .tx_valid   (tx_valid),
   .tx_ready   (tx_ready),
   .spi_miso   (spi_miso),
   .spi_miso_oe(spi_miso_oe),
   .det_mode   (det_mode)
);

// File: tb/spi_autopol_target_test.sv
`timescale 1ns/1ps
module spi_autopol_target_test;

   localparam time HALF = 80ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0;
   logic       cs_n = 1'b1;
   logic       mosi = 1'b0;
   logic       miso, miso_oe, rx_valid, tx_ready, tx_valid = 1'b0;
   logic [7:0] rx_byte, tx_byte = 8'h00;
   logic [1:0] det_mode;

   int vectors = 0;
   int fails   = 0;
   int rx_pulses = 0;
   int rx_high   = 0;
   logic [7:0] rx_last = 8'h00;
   logic       done = 1'b0;

   always #5ns clk = ~clk;

   spi_autopol_target uut (
      .clk(clk), .rst_n(rst_n),
      .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
      .spi_miso(miso), .spi_miso_oe(miso_oe),
      .rx_byte(rx_byte), .rx_valid(rx_valid),
      .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .det_mode(det_mode)
   );

   logic rx_valid_d = 1'b0;
   always @(negedge clk) begin
      if (rx_valid) begin
         rx_high++;
         rx_last = rx_byte;
         if (!rx_valid_d) rx_pulses++;
      end
      rx_valid_d = rx_valid;
   end

   task automatic check(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic load_tx(input logic [7:0] b);
      @(negedge clk);
      while (!tx_ready) @(negedge clk);
      tx_byte  = b;
      tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   task automatic select(input bit m3);
      sclk = m3;
      #(HALF);
      cs_n = 1'b0;
      #(HALF);
   endtask

   task automatic deselect();
      #(HALF);
      cs_n = 1'b1;
      #(4*HALF);
   endtask

   task automatic xfer(input bit m3, input logic [7:0] out_b, input int nbits,
                       output logic [7:0] in_b);
      in_b = 8'h00;
      for (int i = 7; i > 7 - nbits; i--) begin
         if (m3) sclk = 1'b0;
         mosi = out_b[i];
         #(HALF);
         in_b[i] = miso;
         sclk = 1'b1;
         #(HALF);
         if (!m3) sclk = 1'b0;
      end
   endtask

   task automatic t_reset();
      check("R9 rx_valid", rx_valid, 0);
      check("R9 miso_oe", miso_oe, 0);
      check("R9 tx_ready", tx_ready, 1);
      check("R9 det_mode", det_mode, 0);
   endtask

   task automatic t_single(input bit m3, input logic [7:0] tx_b, input logic [7:0] rx_b);
      logic [7:0] got;
      int p0 = rx_pulses;
      load_tx(tx_b);
      check("R5 ready low after accept", tx_ready, 0);
      select(m3);
      check("R1 detected mode", det_mode, m3 ? 3 : 0);
      check("R4 oe while selected", miso_oe, 1);
      check("R5 ready after consume", tx_ready, 1);
      xfer(m3, rx_b, 8, got);
      check("R3 miso byte", got, tx_b);
      #(HALF);
      check("R2 one rx pulse", rx_pulses - p0, 1);
      check("R2 rx byte", rx_last, rx_b);
      deselect();
      check("R4 oe after deselect", miso_oe, 0);
      check("R1 mode kept after deselect", det_mode, m3 ? 3 : 0);
   endtask

   task automatic t_burst();
      logic [7:0] g1, g2;
      int p0 = rx_pulses;
      load_tx(8'h11);
      select(1'b1);
      load_tx(8'hE7);
      check("R5 second byte held", tx_ready, 0);
      xfer(1'b1, 8'h81, 8, g1);
      #(HALF);
      check("R8 first rx byte", rx_last, 8'h81);
      xfer(1'b1, 8'h7E, 8, g2);
      #(HALF);
      check("R8 first miso byte", g1, 8'h11);
      check("R8 second miso byte", g2, 8'hE7);
      check("R8 second rx byte", rx_last, 8'h7E);
      check("R8 two rx pulses", rx_pulses - p0, 2);
      deselect();
   endtask

   task automatic t_fill();
      logic [7:0] got;
      select(1'b0);
      xfer(1'b0, 8'h5C, 8, got);
      check("R6 fill byte on miso", got, 8'h00);
      deselect();
   endtask

   task automatic t_abort();
      logic [7:0] got;
      int p0 = rx_pulses;
      select(1'b0);
      xfer(1'b0, 8'hF0, 4, got);
      deselect();
      check("R7 no pulse on partial byte", rx_pulses - p0, 0);
      load_tx(8'hA3);
      select(1'b0);
      xfer(1'b0, 8'hC3, 8, got);
      #(HALF);
      check("R7 fresh byte after abort", rx_last, 8'hC3);
      check("R7 fresh miso after abort", got, 8'hA3);
      deselect();
   endtask

   initial begin
      #(2ms);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      #(33ns);
      rst_n = 1'b1;
      #(40ns);
      t_reset();
      t_single(1'b0, 8'h96, 8'hA5);
      t_single(1'b1, 8'h5A, 8'h3C);
      t_single(1'b0, 8'h0F, 8'hE1);
      t_burst();
      t_fill();
      t_abort();
      check("R2 pulse width one cycle", rx_high, rx_pulses);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule